// File: doc/BRIEF.md
# Key Event Queue with Live Duration Counter

This block records debounced key state changes in a small ring of entries. Each entry pairs an 8-bit key code with a duration byte. The duration byte holds a 7-bit tick count under a sticky overflow flag in bit 7. The newest entry stays live: its duration keeps counting in place from a slow tick until the next state change closes it. An active-low interrupt tells the host that there is something new to read. An empty flag reports whether any closed entry is still waiting.

The host sees one entry at a time on the read port. If any closed entry is waiting, the port shows the oldest one. A pop strobe, given after the host has taken that entry, clears the entry and moves on. If no closed entry is waiting, the port shows the live entry with its running count. A pop then only marks the live entry as seen, which releases the interrupt; the entry stays in place. A new event when the ring is full discards the oldest waiting entry.

Whether a live entry exists, and whether the host has seen it, is held in a three-state machine:
- LV_NONE: no live entry. This is the state after reset or clear.
- LV_FRESH: a live entry that the host has not read.
- LV_SEEN: a live entry that the host has read.

Transitions:
- NONE→FRESH: on the first event.
- FRESH→SEEN: on a pop while no closed entry waits.
- FRESH→FRESH and SEEN→FRESH: on any event.
- any state→NONE: on reset, shutdown or power-down.

Top module: `keyevt_fifo`

## Requirements
- R1: After reset every entry holds key 0xFF and duration 0x00. The read port shows 0xFF/0x00, empty_o is 1 and irq_n_o is 1.
- R2: An accepted event drives irq_n_o low on the clock edge that stores it.
- R3: The live entry's count (duration bits 6:0) rises by one on each internal tick. A tick comes once every TICK_CYCLES clocks.
- R4: A tick at count 127 wraps the count to 0 and sets duration bit 7. Bit 7 stays set until that entry is cleared or rewritten.
- R5: An event freezes the previous live entry at its final duration and turns it into a waiting closed entry. It writes the new key with duration 0x00. When an event and a tick arrive in the same clock, the event wins.
- R6: With a closed entry waiting, the read port shows the oldest one. A pop resets that entry to 0xFF/0x00 and presents the next one.
- R7: With no closed entry waiting, the read port shows the live key and its current duration. A pop then leaves the entry in place and drives irq_n_o high.
- R8: irq_n_o is high exactly when no closed entry waits and the live entry, if any, has been seen.
- R9: empty_o is 1 exactly when no closed entry waits. Whenever empty_o is 0, irq_n_o is 0.
- R10: At most DEPTH-1 closed entries wait. An event arriving when that many already wait discards the oldest one, and reads resume at the next-oldest.
- R11: A power-down pulse (pdn_i) clears every entry and all pointers, just as reset does. So does shutdown (sleep_i high); events that arrive while sleep_i is high are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Shutdown level; while high the queue is held clear |
| pdn_i | input | 1 | Power-down control strobe; clears the queue |
| evt_valid_i | input | 1 | A debounced state change is present this cycle |
| evt_code_i | input | CODE_W | Key code of the new state |
| pop_i | input | 1 | Host has taken the entry on the read port |
| rd_code_o | output | CODE_W | Key code of the presented entry |
| rd_dur_o | output | CNT_W+1 | Duration of the presented entry (overflow flag in the top bit) |
| irq_n_o | output | 1 | Interrupt, active low |
| empty_o | output | 1 | No closed entry waiting |

## Verification
Some properties are checked by assertions on every cycle:
- an event always pulls the interrupt low;
- the waiting count never exceeds DEPTH-1;
- a non-empty queue never leaves the interrupt high;
- a clear always yields an empty, quiet queue;
- an overflow flag never drops by itself;
- ticks never come on adjacent cycles;
- a pop of the live entry leaves it in place.

Other properties can only be shown by the bench scenarios, which run against a behavioural reference model:
- the exact duration values;
- which entry an overflow discards;
- the order in which codes come out;
- how a read of a held key differs from a read of a released one.

// File: rtl/keyevt_pkg.sv
package keyevt_pkg;

    typedef enum logic [1:0] {
        LV_NONE  = 2'd0,
        LV_FRESH = 2'd1,
        LV_SEEN  = 2'd2
    } live_state_e;

endpackage

// File: rtl/keyevt_tick.sv
module keyevt_tick #(
    parameter int unsigned TICK_CYCLES = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic tick_o
);
    localparam int unsigned TW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [TW-1:0] LAST = TW'(TICK_CYCLES - 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else if (clr_i) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q  <= '0;
            tick_o <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            tick_o <= 1'b0;
        end
    end

    generate
        if (TICK_CYCLES > 1) begin : g_gap_chk
            // R3: ticks are spaced, never back to back
            assert_tick_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/keyevt_store.sv
module keyevt_store #(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned CODE_W = 8,
    parameter int unsigned CNT_W  = 7,
    parameter logic [CODE_W-1:0] BLANK_CODE = '1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr_all_i,
    input  logic                       wr_en_i,
    input  logic [$clog2(DEPTH)-1:0]   wr_idx_i,
    input  logic [CODE_W-1:0]          wr_code_i,
    input  logic                       tick_en_i,
    input  logic [$clog2(DEPTH)-1:0]   live_idx_i,
    input  logic                       pop_en_i,
    input  logic [$clog2(DEPTH)-1:0]   pop_idx_i,
    input  logic [$clog2(DEPTH)-1:0]   rd_idx_i,
    output logic [CODE_W-1:0]          rd_code_o,
    output logic [CNT_W:0]             rd_dur_o
);
    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned DUR_W = CNT_W + 1;

    logic [DEPTH-1:0][CODE_W-1:0] code_all;
    logic [DEPTH-1:0][DUR_W-1:0]  dur_all;

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic [CODE_W-1:0] code_r;
        logic [DUR_W-1:0]  dur_r;
        logic              hit_wr, hit_tick, hit_pop;
        logic [CNT_W-1:0]  cnt_nx;
        logic              of_nx;

        assign hit_wr   = wr_en_i   && (wr_idx_i   == PTR_W'(g));
        assign hit_tick = tick_en_i && (live_idx_i == PTR_W'(g));
        assign hit_pop  = pop_en_i  && (pop_idx_i  == PTR_W'(g));

        always_comb begin
            if (&dur_r[CNT_W-1:0]) begin
                cnt_nx = '0;
                of_nx  = 1'b1;
            end else begin
                cnt_nx = dur_r[CNT_W-1:0] + 1'b1;
                of_nx  = dur_r[CNT_W];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                code_r <= BLANK_CODE;
                dur_r  <= '0;
            end else if (clr_all_i) begin
                code_r <= BLANK_CODE;
                dur_r  <= '0;
            end else if (hit_wr) begin
                code_r <= wr_code_i;
                dur_r  <= '0;
            end else if (hit_tick) begin
                dur_r  <= {of_nx, cnt_nx};
            end else if (hit_pop) begin
                code_r <= BLANK_CODE;
                dur_r  <= '0;
            end
        end

        assign code_all[g] = code_r;
        assign dur_all[g]  = dur_r;

        // R4: overflow flag holds until the entry is cleared or rewritten
        assert_of_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (dur_r[CNT_W] && !clr_all_i && !hit_wr && !hit_pop) |=> dur_r[CNT_W]);
    end

    assign rd_code_o = code_all[rd_idx_i];
    assign rd_dur_o  = dur_all[rd_idx_i];

endmodule

// File: rtl/keyevt_ctrl.sv
module keyevt_ctrl
    import keyevt_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_i,
    input  logic                     tick_i,
    input  logic                     evt_i,
    input  logic                     pop_i,
    output logic                     wr_en_o,
    output logic [$clog2(DEPTH)-1:0] wr_idx_o,
    output logic                     tick_en_o,
    output logic [$clog2(DEPTH)-1:0] live_idx_o,
    output logic                     pop_en_o,
    output logic [$clog2(DEPTH)-1:0] pop_idx_o,
    output logic [$clog2(DEPTH)-1:0] rd_idx_o,
    output logic                     irq_n_o,
    output logic                     empty_o
);
    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned PW    = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] PEND_MAX = PW'(DEPTH - 1);

    live_state_e        state_q, state_d;
    logic [PTR_W-1:0]   live_q, live_d;
    logic [PTR_W-1:0]   rd_q, rd_d;
    logic [PW-1:0]      pend_q, pend_d;
    logic               has_live, pop_done;
    logic [PW-1:0]      pend_pop;
    logic [PTR_W-1:0]   rd_pop;

    assign has_live = (state_q != LV_NONE);
    assign pop_done = pop_i && (pend_q != '0);

    // next state of the live entry
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LV_NONE:  if (evt_i) state_d = LV_FRESH;
            LV_FRESH: begin
                if (evt_i)                         state_d = LV_FRESH;
                else if (pop_i && pend_q == '0)    state_d = LV_SEEN;
            end
            LV_SEEN:  if (evt_i) state_d = LV_FRESH;
            default:  state_d = LV_NONE;
        endcase
        if (clr_i) state_d = LV_NONE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LV_NONE;
        else        state_q <= state_d;
    end

    // pointers: pop applies first, then the event
    always_comb begin
        pend_pop = pend_q - PW'(pop_done);
        rd_pop   = rd_q + PTR_W'(pop_done);
        pend_d   = pend_pop;
        rd_d     = rd_pop;
        live_d   = live_q;
        if (evt_i && has_live) begin
            live_d = live_q + 1'b1;
            if (pend_pop == PEND_MAX) begin
                pend_d = PEND_MAX;
                rd_d   = rd_pop + 1'b1;
            end else begin
                pend_d = pend_pop + 1'b1;
            end
        end
        if (clr_i) begin
            pend_d = '0;
            rd_d   = '0;
            live_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            rd_q   <= '0;
            live_q <= '0;
        end else begin
            pend_q <= pend_d;
            rd_q   <= rd_d;
            live_q <= live_d;
        end
    end

    // outputs
    always_comb begin
        wr_en_o    = evt_i && !clr_i;
        wr_idx_o   = has_live ? live_q + 1'b1 : live_q;
        tick_en_o  = tick_i && has_live && !evt_i && !clr_i;
        live_idx_o = live_q;
        pop_en_o   = pop_done && !clr_i;
        pop_idx_o  = rd_q;
        rd_idx_o   = (pend_q != '0) ? rd_q : live_q;
        empty_o    = (pend_q == '0);
        irq_n_o    = !((pend_q != '0) || (state_q == LV_FRESH));
    end

    assert_irq_on_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && !clr_i) |=> !irq_n_o);

    assert_pend_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q <= PEND_MAX);

    assert_empty_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !empty_o |-> !irq_n_o);

    assert_clear_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (empty_o && irq_n_o));

    assert_live_read_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && pend_q == '0 && has_live && !evt_i && !clr_i)
            |=> ($stable(live_q) && pend_q == '0 && irq_n_o));

endmodule

// File: rtl/keyevt_fifo.sv
module keyevt_fifo #(
    parameter int unsigned DEPTH       = 8,
    parameter int unsigned CODE_W      = 8,
    parameter int unsigned CNT_W       = 7,
    parameter int unsigned TICK_CYCLES = 32768,
    parameter logic [CODE_W-1:0] BLANK_CODE = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_i,
    input  logic              pdn_i,
    input  logic              evt_valid_i,
    input  logic [CODE_W-1:0] evt_code_i,
    input  logic              pop_i,
    output logic [CODE_W-1:0] rd_code_o,
    output logic [CNT_W:0]    rd_dur_o,
    output logic              irq_n_o,
    output logic              empty_o
);
    localparam int unsigned PTR_W = $clog2(DEPTH);

    logic             clr, tick;
    logic             wr_en, tick_en, pop_en;
    logic [PTR_W-1:0] wr_idx, live_idx, pop_idx, rd_idx;

    assign clr = sleep_i || pdn_i;

    keyevt_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr),
        .tick_o (tick)
    );

    keyevt_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clr),
        .tick_i     (tick),
        .evt_i      (evt_valid_i),
        .pop_i      (pop_i),
        .wr_en_o    (wr_en),
        .wr_idx_o   (wr_idx),
        .tick_en_o  (tick_en),
        .live_idx_o (live_idx),
        .pop_en_o   (pop_en),
        .pop_idx_o  (pop_idx),
        .rd_idx_o   (rd_idx),
        .irq_n_o    (irq_n_o),
        .empty_o    (empty_o)
    );

    keyevt_store #(
        .DEPTH      (DEPTH),
        .CODE_W     (CODE_W),
        .CNT_W      (CNT_W),
        .BLANK_CODE (BLANK_CODE)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_all_i  (clr),
        .wr_en_i    (wr_en),
        .wr_idx_i   (wr_idx),
        .wr_code_i  (evt_code_i),
        .tick_en_i  (tick_en),
        .live_idx_i (live_idx),
        .pop_en_i   (pop_en),
        .pop_idx_i  (pop_idx),
        .rd_idx_i   (rd_idx),
        .rd_code_o  (rd_code_o),
        .rd_dur_o   (rd_dur_o)
    );

endmodule

// File: tb/keyevt_fifo_test.sv
module keyevt_fifo_test;
    localparam int CLK_PERIOD = 10;
    localparam int TICKS      = 4;
    localparam int DEPTH      = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_i = 1'b0;
    logic       pdn_i = 1'b0;
    logic       evt_valid_i = 1'b0;
    logic [7:0] evt_code_i = 8'h00;
    logic       pop_i = 1'b0;
    logic [7:0] rd_code_o;
    logic [7:0] rd_dur_o;
    logic       irq_n_o;
    logic       empty_o;

    keyevt_fifo #(.DEPTH(DEPTH), .CODE_W(8), .CNT_W(7), .TICK_CYCLES(TICKS)) uut (
        .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .pdn_i(pdn_i),
        .evt_valid_i(evt_valid_i), .evt_code_i(evt_code_i), .pop_i(pop_i),
        .rd_code_o(rd_code_o), .rd_dur_o(rd_dur_o), .irq_n_o(irq_n_o), .empty_o(empty_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    nchecks = 0;
    int    nerr = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    task automatic chk(string req, string what, int act, int exp);
        nchecks++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // behavioural reference
    int m_code[DEPTH];
    int m_dur[DEPTH];
    int m_pend, m_rd, m_live, m_cnt;
    bit m_has, m_seen, m_tick;

    task automatic m_blank();
        for (int i = 0; i < DEPTH; i++) begin
            m_code[i] = 255;
            m_dur[i]  = 0;
        end
        m_pend = 0; m_rd = 0; m_live = 0; m_cnt = 0;
        m_has = 0; m_seen = 0; m_tick = 0;
    endtask

    function automatic int bump(int d);
        int c;
        c = d & 127;
        if (c == 127) return 128;
        return (d & 128) | (c + 1);
    endfunction

    initial m_blank();

    always @(posedge clk or negedge rst_n) begin : ref_model
        bit tk;
        if (!rst_n || sleep_i || pdn_i) begin
            m_blank();
        end else begin
            tk = m_tick;
            if (m_cnt == TICKS - 1) begin m_cnt = 0; m_tick = 1; end
            else begin m_cnt++; m_tick = 0; end
            if (pop_i) begin
                if (m_pend > 0) begin
                    m_code[m_rd] = 255; m_dur[m_rd] = 0;
                    m_rd = (m_rd + 1) % DEPTH; m_pend--;
                end else if (m_has) m_seen = 1;
            end
            if (tk && m_has && !evt_valid_i) m_dur[m_live] = bump(m_dur[m_live]);
            if (evt_valid_i) begin
                if (m_has) begin
                    m_pend++;
                    m_live = (m_live + 1) % DEPTH;
                    if (m_pend == DEPTH) begin
                        m_pend = DEPTH - 1;
                        m_rd = (m_rd + 1) % DEPTH;
                    end
                end
                m_has = 1; m_seen = 0;
                m_code[m_live] = int'(evt_code_i);
                m_dur[m_live]  = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            int idx;
            idx = (m_pend > 0) ? m_rd : m_live;
            chk(cur_req, "model code", int'(rd_code_o), m_code[idx]);
            chk(cur_req, "model dur", int'(rd_dur_o), m_dur[idx]);
            chk(cur_req, "model empty", int'(empty_o), (m_pend == 0) ? 1 : 0);
            chk(cur_req, "model irq_n", int'(irq_n_o), (m_pend > 0 || (m_has && !m_seen)) ? 0 : 1);
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic send(logic [7:0] c);
        @(negedge clk); #1;
        evt_valid_i = 1'b1; evt_code_i = c;
        @(negedge clk); #1;
        evt_valid_i = 1'b0;
    endtask

    task automatic do_pop();
        @(negedge clk); #1;
        pop_i = 1'b1;
        @(negedge clk); #1;
        pop_i = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        step(1);
        chk("R1", "reset code", int'(rd_code_o), 'hFF);
        chk("R1", "reset dur", int'(rd_dur_o), 0);
        chk("R1", "reset empty", int'(empty_o), 1);
        chk("R1", "reset irq_n", int'(irq_n_o), 1);

        cur_req = "R2";
        send(8'h31);
        chk("R2", "irq after event", int'(irq_n_o), 0);
        chk("R9", "empty with live only", int'(empty_o), 1);
        chk("R5", "new dur", int'(rd_dur_o), 0);
        chk("R7", "live code", int'(rd_code_o), 'h31);

        cur_req = "R3";
        step(TICKS * 5);
        chk("R3", "count after 5 periods", (rd_dur_o >= 8'd4 && rd_dur_o <= 8'd5) ? 1 : 0, 1);

        cur_req = "R7";
        do_pop();
        chk("R7", "irq after live read", int'(irq_n_o), 1);
        chk("R7", "live kept", int'(rd_code_o), 'h31);
        step(TICKS * 2);
        do_pop();
        chk("R7", "live kept again", int'(rd_code_o), 'h31);

        cur_req = "R5";
        send(8'h42);
        chk("R5", "irq on close", int'(irq_n_o), 0);
        chk("R9", "empty with closed", int'(empty_o), 0);
        chk("R5", "oldest closed shown", int'(rd_code_o), 'h31);

        cur_req = "R6";
        do_pop();
        chk("R6", "next after pop", int'(rd_code_o), 'h42);
        chk("R6", "empty after pop", int'(empty_o), 1);
        chk("R8", "irq while live unseen", int'(irq_n_o), 0);
        cur_req = "R8";
        do_pop();
        chk("R8", "irq all seen", int'(irq_n_o), 1);

        cur_req = "R4";
        step(TICKS * 131);
        chk("R4", "overflow set", int'(rd_dur_o[7]), 1);
        step(TICKS * 3);
        chk("R4", "overflow sticky", int'(rd_dur_o[7]), 1);

        cur_req = "R11";
        @(negedge clk); #1 pdn_i = 1'b1;
        @(negedge clk); #1 pdn_i = 1'b0;
        chk("R11", "pdn code", int'(rd_code_o), 'hFF);
        chk("R11", "pdn dur", int'(rd_dur_o), 0);
        chk("R11", "pdn empty", int'(empty_o), 1);
        chk("R11", "pdn irq_n", int'(irq_n_o), 1);

        cur_req = "R10";
        @(negedge clk); #1;
        for (int k = 0; k < 9; k++) begin
            evt_valid_i = 1'b1; evt_code_i = 8'h50 + 8'(k);
            @(negedge clk); #1;
        end
        evt_valid_i = 1'b0;
        chk("R10", "oldest dropped", int'(rd_code_o), 'h51);
        chk("R10", "not empty", int'(empty_o), 0);
        for (int k = 0; k < 6; k++) do_pop();
        chk("R10", "last closed", int'(rd_code_o), 'h57);
        do_pop();
        cur_req = "R8";
        chk("R8", "live after drain", int'(rd_code_o), 'h58);
        chk("R9", "empty after drain", int'(empty_o), 1);
        chk("R8", "irq live unseen", int'(irq_n_o), 0);
        do_pop();
        chk("R8", "irq quiet", int'(irq_n_o), 1);

        cur_req = "R11";
        @(negedge clk); #1 sleep_i = 1'b1;
        step(2);
        evt_valid_i = 1'b1; evt_code_i = 8'h77;
        step(1);
        evt_valid_i = 1'b0;
        chk("R11", "event ignored in sleep", int'(irq_n_o), 1);
        chk("R11", "sleep code", int'(rd_code_o), 'hFF);
        sleep_i = 1'b0;
        step(2);
        chk("R11", "after sleep empty", int'(empty_o), 1);
        chk("R11", "after sleep dur", int'(rd_dur_o), 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule